// File: doc/BRIEF.md
# Register-Immediate Integer Execute Stage

This block is the execute stage of a 32-bit load/store core for instructions that take an immediate, a shift amount or a jump target instead of a second register. A decoder upstream hands it an operation class, the two source operand values, the 16-bit immediate, the 5-bit shift count, the 26-bit jump field, the candidate destination indices and the current program counter. From these it works out a result value, which register receives it, whether that write happens, whether control flow is redirected and to where, and whether a trapping add overflowed.

Every output is a pure function of the present inputs. No state is held, and no clock passes through the block. Each operation extends its immediate in its own way. The arithmetic adds and the signed compare sign-extend it. The logical operations zero-extend it. The unsigned compare sign-extends it first and then compares the two values as unsigned numbers. The jump-and-link operation builds its target from the top four bits of the sequential PC and writes the return address PC+8.

Top module: `imm_exec_unit`

## Requirements
- R1: Class 1 (add, no trap) writes `res` = `rs_val` + sign-extended `imm` modulo 2^32 to index `rt_idx`, and raises no overflow.
- R2: Class 2 (add, trapping) computes the same sum as R1. When the signed sum overflows, `ovf` is 1 and `wr_en` is 0. Otherwise `ovf` is 0. No other class ever raises `ovf`.
- R3: Class 3 (signed set-less-than) writes 1 when `rs_val` is less than sign-extended `imm` as signed 32-bit values, and 0 otherwise. The destination is `rt_idx`.
- R4: Class 4 (unsigned set-less-than) sign-extends `imm` to 32 bits and then writes 1 when `rs_val` is less than that value as unsigned numbers, and 0 otherwise. The destination is `rt_idx`.
- R5: Class 5 writes `rs_val` OR zero-extended `imm`. Class 6 writes `rs_val` XOR zero-extended `imm`. Both go to `rt_idx`.
- R6: Class 7 writes `{imm, 16'h0000}` to `rt_idx`.
- R7: Class 8 writes `rt_val` shifted left by `shamt`, with zeros filling from the right, to index `rd_idx`.
- R8: Class 9 writes `pc` + 8 to register 31 and sets `redir` to 1.
- R9: For class 9, `redir_pc` is `{pc_plus4[31:28], jtarget, 2'b00}`, where pc_plus4 is `pc` + 4.
- R10: Whenever the selected destination index is 0, `wr_en` is 0.
- R11: Class 0 and classes 10 to 15 set every output to zero: `res`, `dest`, `wr_en`, `redir`, `redir_pc` and `ovf`.
- R12: `redir` is 1 only for class 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation class (encodings as listed in R1 to R11) |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand (shift source) |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Shift amount field |
| jtarget | input | 26 | Jump target field |
| rt_idx | input | 5 | Destination index for immediate-form operations |
| rd_idx | input | 5 | Destination index for the shift operation |
| pc | input | 32 | Address of the current instruction |
| res | output | 32 | Result value |
| dest | output | 5 | Destination register index |
| wr_en | output | 1 | Register write enable |
| redir | output | 1 | Control-flow redirect valid |
| redir_pc | output | 32 | Redirect target address |
| ovf | output | 1 | Signed overflow on the trapping add |

## Verification
Every result is combinational, so each output is due in the same cycle its inputs are applied, with no register in between. The bench changes its inputs at the rising edge and compares every output against a behavioural model at the following falling edge. The operands have half a period to settle before any check is taken. Directed vectors cover the overflow boundaries, the unsigned compare against negative immediates, shift extremes and the region carry in the jump target. Pseudo-random vectors across all sixteen classes follow.

// File: rtl/imm_exec_unit.sv
module imm_exec_unit #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int REG_W = 5,
  parameter int JT_W  = 26,
  parameter int LINK_REG = 31
) (
  input  logic [3:0]       op,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [4:0]       shamt,
  input  logic [JT_W-1:0]  jtarget,
  input  logic [REG_W-1:0] rt_idx,
  input  logic [REG_W-1:0] rd_idx,
  input  logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  res,
  output logic [REG_W-1:0] dest,
  output logic             wr_en,
  output logic             redir,
  output logic [XLEN-1:0]  redir_pc,
  output logic             ovf
);
  localparam int EXT_W = XLEN - IMM_W;
  localparam int RGN_W = XLEN - JT_W - 2;

  localparam logic [3:0] OP_ADDU = 4'd1, OP_ADD = 4'd2, OP_SLT = 4'd3,
                         OP_SLTU = 4'd4, OP_OR = 4'd5, OP_XOR = 4'd6,
                         OP_HI = 4'd7, OP_SHL = 4'd8, OP_JL = 4'd9;

  logic [XLEN-1:0] imm_sx, imm_zx, sum, pc4;
  logic            add_ovf;

  assign imm_sx  = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign imm_zx  = {{EXT_W{1'b0}}, imm};
  assign sum     = rs_val + imm_sx;
  assign add_ovf = (rs_val[XLEN-1] == imm_sx[XLEN-1]) && (sum[XLEN-1] != rs_val[XLEN-1]);
  assign pc4     = pc + XLEN'(4);

  logic             act;
  logic [REG_W-1:0] dsel;

  always_comb begin
    res      = '0;
    dsel     = '0;
    act      = 1'b0;
    redir    = 1'b0;
    redir_pc = '0;
    ovf      = 1'b0;
    unique case (op)
      OP_ADDU: begin res = sum; dsel = rt_idx; act = 1'b1; end
      OP_ADD:  begin res = sum; dsel = rt_idx; act = !add_ovf; ovf = add_ovf; end
      OP_SLT:  begin res = XLEN'($signed(rs_val) < $signed(imm_sx)); dsel = rt_idx; act = 1'b1; end
      OP_SLTU: begin res = XLEN'(rs_val < imm_sx); dsel = rt_idx; act = 1'b1; end
      OP_OR:   begin res = rs_val | imm_zx; dsel = rt_idx; act = 1'b1; end
      OP_XOR:  begin res = rs_val ^ imm_zx; dsel = rt_idx; act = 1'b1; end
      OP_HI:   begin res = {imm, {EXT_W{1'b0}}}; dsel = rt_idx; act = 1'b1; end
      OP_SHL:  begin res = rt_val << shamt; dsel = rd_idx; act = 1'b1; end
      OP_JL: begin
        res      = pc + XLEN'(8);
        dsel     = REG_W'(LINK_REG);
        act      = 1'b1;
        redir    = 1'b1;
        redir_pc = {pc4[XLEN-1 -: RGN_W], jtarget, 2'b00};
      end
      default: ;
    endcase
    dest  = dsel;
    wr_en = act && (dsel != '0);

    a_r10_no_zero_write: assert (!(wr_en && dest == '0))
      else $error("write enabled to index zero");
    a_r2_ovf_blocks_write: assert (!(ovf && wr_en))
      else $error("overflow with write enabled");
    a_r2_ovf_only_add: assert (!ovf || op == OP_ADD)
      else $error("overflow outside trapping add");
    a_r12_redir_only_jl: assert (!redir || (op == OP_JL && dest == REG_W'(LINK_REG)))
      else $error("redirect outside jump-and-link");
    a_r9_target_aligned: assert (!redir || redir_pc[1:0] == 2'b00)
      else $error("misaligned redirect target");
    a_r3_slt_boolean: assert (!(op == OP_SLT || op == OP_SLTU) || res[XLEN-1:1] == '0)
      else $error("compare result not boolean");
    a_r6_hi_low_clear: assert (op != OP_HI || res[EXT_W-1:0] == '0)
      else $error("load-upper low half not clear");
  end
endmodule

// File: tb/tb_imm_exec_unit.sv
module tb_imm_exec_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  op;
  logic [31:0] rs_val, rt_val, pc;
  logic [15:0] imm;
  logic [4:0]  shamt, rt_idx, rd_idx;
  logic [25:0] jtarget;
  logic [31:0] res, redir_pc;
  logic [4:0]  dest;
  logic        wr_en, redir, ovf;

  imm_exec_unit dut (.op(op), .rs_val(rs_val), .rt_val(rt_val), .imm(imm), .shamt(shamt),
    .jtarget(jtarget), .rt_idx(rt_idx), .rd_idx(rd_idx), .pc(pc), .res(res), .dest(dest),
    .wr_en(wr_en), .redir(redir), .redir_pc(redir_pc), .ovf(ovf));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h (op=%0d)", tag, what, act, exp, op);
    end
  endtask

  // Behavioural reference, written with integer arithmetic.
  task automatic check_all();
    longint sa, si, s64;
    longint unsigned ua, ui;
    logic [31:0] e_res, e_rpc;
    logic [4:0]  e_dst;
    bit e_w, e_rd, e_ov;
    string tag;
    sa = longint'($signed(rs_val));
    si = longint'($signed(imm));
    ua = longint'(rs_val);
    ui = longint'(unsigned'(32'($signed(imm))));
    e_res = 0; e_dst = 0; e_w = 0; e_rd = 0; e_ov = 0; e_rpc = 0; tag = "R11";
    case (op)
      1: begin tag = "R1"; e_res = 32'(sa + si); e_dst = rt_idx; e_w = 1; end
      2: begin
        tag = "R2"; s64 = sa + si; e_res = 32'(s64); e_dst = rt_idx;
        e_ov = (s64 > 64'sd2147483647) || (s64 < -64'sd2147483648); e_w = !e_ov;
      end
      3: begin tag = "R3"; e_res = (sa < si) ? 1 : 0; e_dst = rt_idx; e_w = 1; end
      4: begin tag = "R4"; e_res = (ua < ui) ? 1 : 0; e_dst = rt_idx; e_w = 1; end
      5: begin tag = "R5"; e_res = rs_val | {16'h0, imm}; e_dst = rt_idx; e_w = 1; end
      6: begin tag = "R5"; e_res = rs_val ^ {16'h0, imm}; e_dst = rt_idx; e_w = 1; end
      7: begin tag = "R6"; e_res = imm * 32'd65536; e_dst = rt_idx; e_w = 1; end
      8: begin tag = "R7"; e_res = 32'(longint'(rt_val) * (64'd1 << shamt)); e_dst = rd_idx; e_w = 1; end
      9: begin
        tag = "R8"; e_res = pc + 8; e_dst = 31; e_w = 1; e_rd = 1;
        e_rpc = ((pc + 4) & 32'hF000_0000) + jtarget * 4;
      end
      default: ;
    endcase
    if (e_dst == 0) begin
      e_w = 0;
      if (op inside {[1:8]}) tag = {tag, "/R10"};
    end
    chk(tag, "res", res, e_res);
    chk(tag, "dest", {27'h0, dest}, {27'h0, e_dst});
    chk(tag, "wr_en", {31'h0, wr_en}, {31'h0, e_w});
    chk((op == 2) ? "R2" : tag, "ovf", {31'h0, ovf}, {31'h0, e_ov});
    chk((op == 9) ? "R12" : tag, "redir", {31'h0, redir}, {31'h0, e_rd});
    chk((op == 9) ? "R9" : tag, "redir_pc", redir_pc, e_rpc);
  endtask

  task automatic apply(logic [3:0] o, logic [31:0] a, logic [31:0] b, logic [15:0] i,
                       logic [4:0] s, logic [25:0] j, logic [4:0] t, logic [4:0] d, logic [31:0] p);
    @(posedge clk);
    op <= o; rs_val <= a; rt_val <= b; imm <= i; shamt <= s;
    jtarget <= j; rt_idx <= t; rd_idx <= d; pc <= p;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    op = 0; rs_val = 32'hDEAD_BEEF; rt_val = 32'h1234_5678; imm = 16'hFFFF;
    shamt = 5'd7; jtarget = 26'h3FF_FFFF; rt_idx = 5'd3; rd_idx = 5'd4; pc = 32'h8000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all();                                    // R11 idle class during reset
    rst_n = 1'b1;
    apply(1, 32'hFFFF_FFFF, 0, 16'h0001, 0, 0, 5, 0, 0);       // R1 wrap to 0
    apply(1, 32'h7FFF_FFFF, 0, 16'h0001, 0, 0, 5, 0, 0);       // R1 no ovf flag
    apply(2, 32'h7FFF_FFFF, 0, 16'h0001, 0, 0, 5, 0, 0);       // R2 positive overflow
    apply(2, 32'h8000_0000, 0, 16'hFFFF, 0, 0, 5, 0, 0);       // R2 negative overflow
    apply(2, 32'h8000_0000, 0, 16'h0001, 0, 0, 5, 0, 0);       // R2 no overflow
    apply(2, 32'h7FFF_FFFE, 0, 16'h0001, 0, 0, 6, 0, 0);       // R2 at the limit
    apply(3, 32'hFFFF_FFFF, 0, 16'h0000, 0, 0, 7, 0, 0);       // R3 -1 < 0
    apply(3, 32'h0000_0005, 0, 16'hFFFF, 0, 0, 7, 0, 0);       // R3 5 < -1 false
    apply(3, 32'hFFFF_FFFE, 0, 16'hFFFF, 0, 0, 7, 0, 0);       // R3 -2 < -1
    apply(4, 32'h0000_0005, 0, 16'hFFFF, 0, 0, 8, 0, 0);       // R4 5 < 0xFFFFFFFF
    apply(4, 32'hFFFF_FFFF, 0, 16'hFFFF, 0, 0, 8, 0, 0);       // R4 equal -> 0
    apply(4, 32'h0000_8000, 0, 16'h8000, 0, 0, 8, 0, 0);       // R4 vs 0xFFFF8000
    apply(4, 32'hFFFF_8000, 0, 16'h0001, 0, 0, 8, 0, 0);       // R4 large rs
    apply(5, 32'h0F00_0000, 0, 16'h8001, 0, 0, 9, 0, 0);       // R5 or zero-ext
    apply(6, 32'hFFFF_FFFF, 0, 16'h8000, 0, 0, 9, 0, 0);       // R5 xor zero-ext
    apply(7, 32'h1234_5678, 0, 16'hABCD, 0, 0, 10, 0, 0);      // R6
    apply(8, 0, 32'h8000_0001, 0, 5'd0, 0, 11, 12, 0);         // R7 shift 0
    apply(8, 0, 32'h8000_0001, 0, 5'd31, 0, 11, 12, 0);        // R7 shift 31
    apply(8, 0, 32'h0000_00F3, 0, 5'd4, 0, 11, 0, 0);          // R7 rd=0 -> R10
    apply(9, 0, 0, 0, 0, 26'h123_4567, 0, 0, 32'h4000_1000);   // R8 R9
    apply(9, 0, 0, 0, 0, 26'h3FF_FFFF, 0, 0, 32'h1FFF_FFFC);   // R9 region carry
    apply(1, 32'h1, 0, 16'h1, 0, 0, 0, 0, 0);                  // R10 rt=0
    apply(7, 32'h1, 0, 16'h1, 0, 0, 0, 0, 0);                  // R10 rt=0
    for (int k = 10; k < 16; k++) apply(4'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 31, 26'h3FF_FFFF, 31, 31, 32'hFFFF_FFFF); // R11
    for (int n = 0; n < 3000; n++)
      apply(4'($urandom), $urandom, $urandom, 16'($urandom), 5'($urandom),
            26'($urandom), 5'($urandom), 5'($urandom), $urandom);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule